// File: doc/BRIEF.md
# Compressed Set Segment Mapper

This block handles the data placement for one set of a compressed cache in which tags and data are not tied to each other. The set has eight tags and a data area of 32 segments, each 8 bytes wide, so four uncompressed 64-byte lines fill it exactly. Every tag carries a state and a line length counted in whole segments, where a partly used last segment counts as a full one. A line has no fixed slot. Its first segment is the total length of all tags with a lower index, so the order of the data always follows the order of the tags. A tag in the invalid state owns no segments and adds zero to that total. A tag in the not-present state has no valid data but keeps its length, so its segments stay reserved.

The mapper has three functions. The first is a combinational query that returns a tag's start segment and raises a layout error when the line would run past the end of the data area. The second is a read sequencer: it takes a tag index and then produces one segment address per cycle, starting at that line's first segment, until the whole line has been covered. The third is an install check for a not-present tag. It reports whether an incoming line fits into the segments the tag already holds, or whether the set must be compacted first.

Top module: `segmap_set`

## Requirements
- R1: `query_start_o` is the sum of the effective lengths of all tags whose index is below `query_idx_i`. It changes in the same cycle as its inputs. Tag k's state is in bits [2k+1:2k] of `tag_state_i` and its length is in bits [4k+3:4k] of `tag_size_i`.
- R2: The state codes are 2'b00 invalid, 2'b01 not-present, and 2'b10 or 2'b11 data-holding. An invalid tag has an effective length of zero. Not-present and data-holding tags contribute their stored length.
- R3: `query_err_o` is 1 exactly when the queried tag's start plus its effective length is greater than 32.
- R4: A read is accepted on the clock edge where `rd_req_i` is 1 and `seg_vld_o` is 0. From the next cycle on, `seg_vld_o` is 1 for as many cycles as the tag's length. `seg_addr_o` starts at the tag's start segment and goes up by one each cycle.
- R5: `seg_last_o` is 1 on the final beat only. `seg_vld_o` returns to 0 in the cycle after that beat.
- R6: A request made while `seg_vld_o` is 1 is ignored. The beats already in progress continue unchanged.
- R7: A request for a tag whose effective length is zero, or whose layout is in error (R3), produces no beats.
- R8: For a not-present tag, if the new length `fit_size_i` is no larger than the tag's stored length and no larger than 8, then `fit_inplace_o` is 1 and `fit_compact_o` is 0.
- R9: For a not-present tag, if the new length is larger than the stored length or larger than 8, then `fit_compact_o` is 1 and `fit_inplace_o` is 0.
- R10: For a tag that is not in the not-present state, both `fit_inplace_o` and `fit_compact_o` are 0.
- R11: While `rst_n` is low, `seg_vld_o` and `seg_last_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tag_state_i | input | 16 | Two-bit state per tag |
| tag_size_i | input | 32 | Four-bit segment length per tag |
| query_idx_i | input | 3 | Tag index to place |
| query_start_o | output | 7 | Start segment of the queried tag |
| query_err_o | output | 1 | Queried line runs past the data area |
| rd_req_i | input | 1 | Start a segment read |
| rd_idx_i | input | 3 | Tag index to read |
| seg_addr_o | output | 5 | Segment address of the current beat |
| seg_vld_o | output | 1 | Beat valid; also means the sequencer is busy |
| seg_last_o | output | 1 | Final beat of the line |
| fit_idx_i | input | 3 | Not-present tag that is the install target |
| fit_size_i | input | 4 | Length of the incoming line |
| fit_inplace_o | output | 1 | Line can be written in place |
| fit_compact_o | output | 1 | Compaction is needed before the install |

## Verification
The query and install outputs are combinational. The bench therefore checks them one time step after it changes the inputs, with no clock edge in between. A read request is applied at a falling edge and is accepted at the next rising edge. The first beat then appears at the falling edge after that, and each later beat one falling edge further on. The bench compares beat k at the (k+1)-th falling edge after the request and checks for an idle output one edge after the final beat. For requests that must be ignored or rejected, the bench watches the beat outputs over the same window and expects them to be unchanged or idle.

// File: rtl/segmap_pkg.sv
package segmap_pkg;
  localparam int ST_W = 2;

  typedef enum logic [1:0] {
    TS_INVALID = 2'b00,
    TS_NOTPRES = 2'b01,
    TS_HELD    = 2'b10,
    TS_HELD_MD = 2'b11
  } tag_state_e;

  function automatic logic owns_segments(input logic [1:0] st);
    return st != TS_INVALID;
  endfunction

  function automatic logic is_notpresent(input logic [1:0] st);
    return st == TS_NOTPRES;
  endfunction
endpackage

// File: rtl/segmap_prefix.sv
module segmap_prefix #(
  parameter int NUM_TAGS = 8,
  parameter int SIZE_W   = 4,
  parameter int SUM_W    = 7
) (
  input  logic [NUM_TAGS*2-1:0]      state_i,
  input  logic [NUM_TAGS*SIZE_W-1:0] size_i,
  output logic [NUM_TAGS*SUM_W-1:0]  start_o,
  output logic [NUM_TAGS*SIZE_W-1:0] eff_o
);
  import segmap_pkg::*;
  localparam int LEVELS = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1;

  logic [SUM_W-1:0] acc [LEVELS+1][NUM_TAGS];

  function automatic logic [SIZE_W-1:0] eff_len(input logic [1:0] st,
                                                input logic [SIZE_W-1:0] sz);
    return owns_segments(st) ? sz : '0;
  endfunction

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_leaf
    assign eff_o[i*SIZE_W +: SIZE_W] = eff_len(state_i[i*2 +: 2], size_i[i*SIZE_W +: SIZE_W]);
    assign acc[0][i] = SUM_W'(eff_o[i*SIZE_W +: SIZE_W]);
  end

  // Parallel prefix: each level adds the partial sum from 2^(l-1) tags below
  for (genvar l = 1; l <= LEVELS; l++) begin : g_lvl
    for (genvar i = 0; i < NUM_TAGS; i++) begin : g_node
      if (i >= (1 << (l-1))) begin : g_add
        assign acc[l][i] = acc[l-1][i] + acc[l-1][i - (1 << (l-1))];
      end else begin : g_pass
        assign acc[l][i] = acc[l-1][i];
      end
    end
  end

  for (genvar i = 0; i < NUM_TAGS; i++) begin : g_start
    if (i == 0) begin : g_zero
      assign start_o[0 +: SUM_W] = '0;
    end else begin : g_excl
      assign start_o[i*SUM_W +: SUM_W] = acc[LEVELS][i-1];
    end
  end
endmodule

// File: rtl/segmap_fit.sv
module segmap_fit #(
  parameter int SIZE_W        = 4,
  parameter int MAX_LINE_SEGS = 8
) (
  input  logic [1:0]        state_i,
  input  logic [SIZE_W-1:0] have_i,
  input  logic [SIZE_W-1:0] want_i,
  output logic              inplace_o,
  output logic              compact_o
);
  import segmap_pkg::*;

  function automatic logic fits(input logic [SIZE_W-1:0] have,
                                input logic [SIZE_W-1:0] want);
    return (want <= have) && (int'(want) <= MAX_LINE_SEGS);
  endfunction

  logic np_target;
  assign np_target = is_notpresent(state_i);
  assign inplace_o = np_target && fits(have_i, want_i);
  assign compact_o = np_target && !fits(have_i, want_i);
endmodule

// File: rtl/segmap_seq.sv
module segmap_seq #(
  parameter int SEG_AW = 5,
  parameter int SIZE_W = 4,
  parameter int SUM_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go_i,
  input  logic [SUM_W-1:0]  start_i,
  input  logic [SIZE_W-1:0] len_i,
  output logic [SEG_AW-1:0] addr_o,
  output logic              vld_o,
  output logic              last_o
);
  logic [SIZE_W-1:0] left_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
      left_q <= '0;
    end else if (go_i && !vld_o) begin
      vld_o  <= 1'b1;
      addr_o <= start_i[SEG_AW-1:0];
      left_q <= len_i - 1'b1;
    end else if (vld_o) begin
      if (left_q == '0) begin
        vld_o <= 1'b0;
      end else begin
        addr_o <= addr_o + 1'b1;
        left_q <= left_q - 1'b1;
      end
    end
  end

  assign last_o = vld_o && (left_q == '0);

  assert_first_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && !vld_o) |=> (vld_o && addr_o == $past(start_i[SEG_AW-1:0])));
  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !last_o) |=> (vld_o && addr_o == SEG_AW'($past(addr_o) + 1'b1)));
  assert_last_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |=> !vld_o);
  assert_reset_idle_R11: assert property (@(posedge clk)
    !rst_n |-> (!vld_o && !last_o));
endmodule

// File: rtl/segmap_set.sv
module segmap_set #(
  parameter int NUM_TAGS      = 8,
  parameter int NUM_SEGS      = 32,
  parameter int SIZE_W        = 4,
  parameter int MAX_LINE_SEGS = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_TAGS*2-1:0]              tag_state_i,
  input  logic [NUM_TAGS*SIZE_W-1:0]         tag_size_i,
  input  logic [$clog2(NUM_TAGS)-1:0]        query_idx_i,
  output logic [$clog2(NUM_TAGS*((1<<SIZE_W)-1)+1)-1:0] query_start_o,
  output logic                               query_err_o,
  input  logic                               rd_req_i,
  input  logic [$clog2(NUM_TAGS)-1:0]        rd_idx_i,
  output logic [$clog2(NUM_SEGS)-1:0]        seg_addr_o,
  output logic                               seg_vld_o,
  output logic                               seg_last_o,
  input  logic [$clog2(NUM_TAGS)-1:0]        fit_idx_i,
  input  logic [SIZE_W-1:0]                  fit_size_i,
  output logic                               fit_inplace_o,
  output logic                               fit_compact_o
);
  import segmap_pkg::*;
  localparam int IDX_W  = $clog2(NUM_TAGS);
  localparam int SEG_AW = $clog2(NUM_SEGS);
  localparam int SUM_W  = $clog2(NUM_TAGS*((1<<SIZE_W)-1)+1);

  logic [NUM_TAGS*SUM_W-1:0]  starts;
  logic [NUM_TAGS*SIZE_W-1:0] effs;

  segmap_prefix #(.NUM_TAGS(NUM_TAGS), .SIZE_W(SIZE_W), .SUM_W(SUM_W)) u_prefix (
    .state_i (tag_state_i),
    .size_i  (tag_size_i),
    .start_o (starts),
    .eff_o   (effs)
  );

  function automatic logic overruns(input logic [SUM_W-1:0] st,
                                    input logic [SIZE_W-1:0] len);
    return (int'(st) + int'(len)) > NUM_SEGS;
  endfunction

  // Query path
  logic [SIZE_W-1:0] q_eff;
  assign query_start_o = starts[query_idx_i*SUM_W +: SUM_W];
  assign q_eff         = effs[query_idx_i*SIZE_W +: SIZE_W];
  assign query_err_o   = overruns(query_start_o, q_eff);

  // Read path
  logic [SUM_W-1:0]  rd_start;
  logic [SIZE_W-1:0] rd_eff;
  logic              rd_bad;
  logic              rd_go;
  assign rd_start = starts[rd_idx_i*SUM_W +: SUM_W];
  assign rd_eff   = effs[rd_idx_i*SIZE_W +: SIZE_W];
  assign rd_bad   = (rd_eff == '0) || overruns(rd_start, rd_eff);
  assign rd_go    = rd_req_i && !seg_vld_o && !rd_bad;

  segmap_seq #(.SEG_AW(SEG_AW), .SIZE_W(SIZE_W), .SUM_W(SUM_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (rd_go),
    .start_i (rd_start),
    .len_i   (rd_eff),
    .addr_o  (seg_addr_o),
    .vld_o   (seg_vld_o),
    .last_o  (seg_last_o)
  );

  // Install fit path
  logic [1:0] fit_state;
  assign fit_state = tag_state_i[fit_idx_i*2 +: 2];

  segmap_fit #(.SIZE_W(SIZE_W), .MAX_LINE_SEGS(MAX_LINE_SEGS)) u_fit (
    .state_i   (fit_state),
    .have_i    (tag_size_i[fit_idx_i*SIZE_W +: SIZE_W]),
    .want_i    (fit_size_i),
    .inplace_o (fit_inplace_o),
    .compact_o (fit_compact_o)
  );

  assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && seg_vld_o && !seg_last_o) |=>
      (seg_vld_o && seg_addr_o == SEG_AW'($past(seg_addr_o) + 1'b1)));
  assert_reject_bad_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && !seg_vld_o && rd_bad) |=> !seg_vld_o);
  assert_fit_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(fit_inplace_o && fit_compact_o));
  assert_fit_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_notpresent(fit_state) |-> (!fit_inplace_o && !fit_compact_o));
  assert_np_decides_R9: assert property (@(posedge clk) disable iff (!rst_n)
    is_notpresent(fit_state) |-> (fit_inplace_o || fit_compact_o));
endmodule

// File: tb/test_segmap_set.sv
module test_segmap_set;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] tag_state_i = '0;
  logic [31:0] tag_size_i = '0;
  logic [2:0]  query_idx_i = '0;
  logic [6:0]  query_start_o;
  logic        query_err_o;
  logic        rd_req_i = 1'b0;
  logic [2:0]  rd_idx_i = '0;
  logic [4:0]  seg_addr_o;
  logic        seg_vld_o;
  logic        seg_last_o;
  logic [2:0]  fit_idx_i = '0;
  logic [3:0]  fit_size_i = '0;
  logic        fit_inplace_o;
  logic        fit_compact_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  segmap_set i_segmap_set (.*);

  typedef struct packed {
    logic [15:0] st;
    logic [31:0] sz;
    logic [2:0]  idx;
    logic [6:0]  start;
    logic        err;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{16'hAAAA, 32'h44444444, 3'd4, 7'd16, 1'b0},
    '{16'hAAAA, 32'h44444444, 3'd7, 7'd28, 1'b0},
    '{16'hAAAA, 32'h88888888, 3'd4, 7'd32, 1'b1},
    '{16'hAA00, 32'h88888888, 3'd4, 7'd0,  1'b0},
    '{16'hAA00, 32'h88888888, 3'd7, 7'd24, 1'b0},
    '{16'hAA86, 32'h12345678, 3'd5, 7'd24, 1'b0},
    '{16'hAA86, 32'h12345678, 3'd0, 7'd0,  1'b0},
    '{16'hAA86, 32'h12345678, 3'd7, 7'd29, 1'b0},
    '{16'hAAAA, 32'h00000000, 3'd7, 7'd0,  1'b0},
    '{16'hAA86, 32'h12345678, 3'd2, 7'd15, 1'b0},
    '{16'h5555, 32'h88888888, 3'd3, 7'd24, 1'b0},
    '{16'hAAAA, 32'h88888888, 3'd3, 7'd24, 1'b0}
  };

  task automatic chk(input string req, input int got, input int exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, got, exp);
    end
  endtask

  // Expects n beats from start; optionally pokes another request while busy
  task automatic do_read(input logic [2:0] idx, input int start, input int n,
                         input bit noise, input string req);
    @(negedge clk);
    rd_idx_i = idx;
    rd_req_i = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (noise && k < n-1) begin
        rd_req_i = 1'b1;
        rd_idx_i = idx + 3'd1;
      end else begin
        rd_req_i = 1'b0;
      end
      chk({req, " vld"},  seg_vld_o, 1);
      chk({req, " addr"}, seg_addr_o, start + k);
      chk({req, " last"}, seg_last_o, (k == n-1) ? 1 : 0);
    end
    @(negedge clk);
    chk({req, " idle after last R5"}, seg_vld_o, 0);
  endtask

  task automatic no_read(input logic [2:0] idx, input string req);
    @(negedge clk);
    rd_idx_i = idx;
    rd_req_i = 1'b1;
    @(negedge clk);
    rd_req_i = 1'b0;
    chk(req, seg_vld_o, 0);
    @(negedge clk);
    chk(req, seg_vld_o, 0);
  endtask

  task automatic fit(input logic [2:0] idx, input logic [3:0] sz,
                     input int e_in, input int e_cp, input string req);
    fit_idx_i  = idx;
    fit_size_i = sz;
    #1;
    chk({req, " inplace"}, fit_inplace_o, e_in);
    chk({req, " compact"}, fit_compact_o, e_cp);
  endtask

  initial begin
    // R11: outputs idle during reset
    repeat (3) @(negedge clk);
    chk("R11 vld in reset", seg_vld_o, 0);
    chk("R11 last in reset", seg_last_o, 0);
    rst_n = 1'b1;

    // R1 R2 R3: placement vectors
    for (int v = 0; v < NV; v++) begin
      tag_state_i = VECS[v].st;
      tag_size_i  = VECS[v].sz;
      query_idx_i = VECS[v].idx;
      #1;
      chk("R1 R2 start", query_start_o, VECS[v].start);
      chk("R3 layout err", query_err_o, VECS[v].err);
    end

    // R4 R5 reads on the mixed layout
    tag_state_i = 16'hAA86;
    tag_size_i  = 32'h12345678;
    do_read(3'd3, 15, 5, 1'b0, "R4 read tag3");
    do_read(3'd7, 29, 1, 1'b0, "R5 single beat");
    // R6: extra requests while busy are ignored
    do_read(3'd0, 0, 8, 1'b1, "R6 busy ignore");
    do_read(3'd1, 8, 7, 1'b0, "R4 read not-present tag");
    // R7: invalid tag and overrunning tag produce no beats
    no_read(3'd2, "R7 zero length");
    tag_state_i = 16'hAAAA;
    tag_size_i  = 32'h88888888;
    no_read(3'd5, "R7 layout error");
    do_read(3'd3, 24, 8, 1'b0, "R4 read ends at boundary");

    // R8 R9 R10 install fit
    tag_state_i = 16'hAA86;
    tag_size_i  = 32'h12345678;
    fit(3'd1, 4'd7, 1, 0, "R8 equal fits");
    fit(3'd1, 4'd3, 1, 0, "R8 smaller fits");
    fit(3'd1, 4'd8, 0, 1, "R9 larger compacts");
    fit(3'd0, 4'd2, 0, 0, "R10 held tag");
    fit(3'd2, 4'd2, 0, 0, "R10 invalid tag");
    tag_state_i = 16'hAAA9;
    tag_size_i  = 32'h88888888;
    fit(3'd0, 4'd8, 1, 0, "R8 full size fits");
    fit(3'd0, 4'd9, 0, 1, "R9 over eight");
    fit(3'd0, 4'd15, 0, 1, "R9 max code");

    // R11: reset in the middle of a read
    @(negedge clk);
    rd_idx_i = 3'd0;
    rd_req_i = 1'b1;
    @(negedge clk);
    rd_req_i = 1'b0;
    rst_n = 1'b0;
    #1;
    chk("R11 vld after async reset", seg_vld_o, 0);
    chk("R11 last after async reset", seg_last_o, 0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule